// File: doc/BRIEF.md
# Key Slot Store with Private Export

This block holds a small bank of secret key slots for a security subsystem. Software fills a slot one 32-bit word at a time. Each word can be written only once. Software then gives the slot a destination address and an export configuration, and locks it. Once a slot is locked, software can no longer read it or change it. After that, the only thing software can do with the slot is ask for its key to be pushed to a crypto engine over a private write channel. Software can also invalidate the slot, which wipes it.

The lowest-numbered slots are hardware slots. A lifecycle controller fills them with one pulse after reset, using a default address and configuration set by parameters. From then on they act like locked software slots. Once a hardware slot is invalidated it stays unusable until the next reset.

The export sequencer sends one key word per beat. The destination is either one fixed address written repeatedly, or a run of word addresses that rises by 4 per beat. In masked mode each key word goes out XORed with a fresh random mask word, and the mask word follows on the next beat, so the receiver can XOR the two back together. A command that breaks an access rule is refused. It changes no state and sets a sticky error flag.

Top module: `kmu_keyslot_unit`

## Requirements
- R1: After reset, software slots are open and empty, hardware slots refuse every command except invalidate until loaded, `exp_valid`, `exp_busy`, `exp_done` and `err_flag` are 0, and `rd_data` is 0.
- R2: Commands are accepted on a `cmd_valid` cycle with opcodes 0 write word, 1 read word, 2 set address, 3 set config, 4 lock, 5 export, 6 invalidate. In an open slot each key word can be written once; a second write to it is refused and leaves the word unchanged. A read of an open slot returns the word in `rd_data` on the next cycle, and an unwritten word reads as 0.
- R3: The address and the config are each write-once. A config's size code in bits [1:0] must be 0 (128 bits, 4 words), 1 (192 bits, 6 words) or 2 (256 bits, 8 words); code 3 is refused. Lock is refused unless both address and config are set.
- R4: In a locked slot, reads are refused and return 0, and key writes, config writes and a second lock are all refused.
- R5: Export is accepted only for a locked slot while the sequencer is idle. It sends 4, 6 or 8 key words, word 0 first.
- R6: Config bit 2 set means the beat address is the base plus 4 times the word index; bit 2 clear means every beat goes to the base address. While `exp_ready` is low, `exp_valid`, `exp_addr` and `exp_data` hold.
- R7: Config bit 3 set means each word takes two beats to the same address. The first beat carries key XOR mask and the second carries the mask. A new mask is taken from `rnd_word` for each word.
- R8: A `hw_load` pulse fills each hardware slot from `hw_key` (word i at bits 32i+31:32i), with the parameter address and config, and locks it. Only the first load after reset takes effect.
- R9: Invalidate wipes the key, address and config. A software slot becomes open and reusable; a hardware slot stays refused until reset. Invalidating the slot that is being exported is refused.
- R10: `err_flag` is set by any refused command, including opcode 7 and export while busy. It holds until an `err_clr` cycle that has no refusal. `exp_done` pulses for one cycle right after the last beat's handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_slot | input | SLOT_W | Target slot |
| cmd_idx | input | 3 | Key word index |
| cmd_data | input | 32 | Write data, address or config |
| err_clr | input | 1 | Clears the sticky error |
| rd_data | output | 32 | Read result |
| err_flag | output | 1 | Sticky refusal flag |
| hw_load | input | 1 | Lifecycle load pulse for hardware slots |
| hw_key | input | NUM_HW*256 | Hardware slot key material |
| rnd_word | input | 32 | Random mask source |
| exp_valid | output | 1 | Export beat valid |
| exp_ready | input | 1 | Export beat accepted |
| exp_addr | output | ADDR_W | Export beat address |
| exp_data | output | 32 | Export beat data |
| exp_busy | output | 1 | Export in progress |
| exp_done | output | 1 | One-cycle end-of-export pulse |

## Verification
The access rules are exercised with a table of command sequences on one software slot. The table mixes legal and refused writes, reads, configs and locks. It separates write-once-per-word from write-once-per-slot, and tells a refused lock apart from a missing field. Exports run three patterns. An unmasked 128-bit export to rising addresses under backpressure checks word order and holding. A masked 192-bit export to one fixed address checks that each pair XORs back to the key and that masks change per word. A 256-bit export from a hardware slot checks the default settings and that the first load persists. Invalidation is checked on both slot kinds, and refusals are checked while an export is in flight.

// File: rtl/kmu_pkg.sv
package kmu_pkg;
  localparam int WORD_W    = 32;
  localparam int KEY_WORDS = 8;
  localparam int KEY_BITS  = KEY_WORDS * WORD_W;
  localparam int IDX_W     = $clog2(KEY_WORDS);
  localparam int CFG_W     = 4;
  localparam int CFG_INCR  = 2;
  localparam int CFG_MASK  = 3;

  typedef enum logic [2:0] {
    OP_WRITE_KEY = 3'd0,
    OP_READ_KEY  = 3'd1,
    OP_SET_ADDR  = 3'd2,
    OP_SET_CFG   = 3'd3,
    OP_LOCK      = 3'd4,
    OP_EXPORT    = 3'd5,
    OP_INVAL     = 3'd6,
    OP_RSVD      = 3'd7
  } kmu_op_e;

  typedef enum logic [1:0] {
    SL_OPEN    = 2'd0,
    SL_LOCKED  = 2'd1,
    SL_WAIT_HW = 2'd2,
    SL_DEAD    = 2'd3
  } slot_state_e;

  function automatic logic [3:0] words_for(input logic [1:0] size_code);
    case (size_code)
      2'd0:    return 4'd4;
      2'd1:    return 4'd6;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/kmu_key_slot.sv
module kmu_key_slot
  import kmu_pkg::*;
#(
  parameter bit              IS_HW    = 1'b0,
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] DEF_ADDR = '0,
  parameter logic [CFG_W-1:0]  DEF_CFG  = '0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             hw_load,
  input  logic [KEY_BITS-1:0]              hw_key,
  input  logic                             op_en,
  input  kmu_op_e                          op,
  input  logic [IDX_W-1:0]                 idx,
  input  logic [WORD_W-1:0]                wdata,
  input  logic                             exporting,
  output logic                             refuse_o,
  output logic [KEY_WORDS-1:0][WORD_W-1:0] key_o,
  output logic [ADDR_W-1:0]                addr_o,
  output logic [CFG_W-1:0]                 cfg_o
);
  localparam slot_state_e RESET_ST = IS_HW ? SL_WAIT_HW : SL_OPEN;
  localparam slot_state_e INVAL_ST = IS_HW ? SL_DEAD : SL_OPEN;

  slot_state_e                     st_q, st_n;
  logic [KEY_WORDS-1:0][WORD_W-1:0] key_q, key_n;
  logic [KEY_WORDS-1:0]            wr_q, wr_n;
  logic [ADDR_W-1:0]               addr_q, addr_n;
  logic [CFG_W-1:0]                cfg_q, cfg_n;
  logic                            aset_q, aset_n, cset_q, cset_n;
  logic                            refuse;
  logic                            upd_en;

  assign upd_en = hw_load | op_en;

  always_comb begin
    st_n   = st_q;
    key_n  = key_q;
    wr_n   = wr_q;
    addr_n = addr_q;
    cfg_n  = cfg_q;
    aset_n = aset_q;
    cset_n = cset_q;
    refuse = 1'b0;
    if (hw_load && st_q == SL_WAIT_HW) begin
      key_n  = hw_key;
      wr_n   = '1;
      addr_n = DEF_ADDR;
      cfg_n  = DEF_CFG;
      aset_n = 1'b1;
      cset_n = 1'b1;
      st_n   = SL_LOCKED;
    end
    if (op_en) begin
      case (op)
        OP_WRITE_KEY: begin
          if (st_q == SL_OPEN && !wr_q[idx]) begin
            key_n[idx] = wdata;
            wr_n[idx]  = 1'b1;
          end else refuse = 1'b1;
        end
        OP_READ_KEY: refuse = (st_q != SL_OPEN);
        OP_SET_ADDR: begin
          if (st_q == SL_OPEN && !aset_q) begin
            addr_n = ADDR_W'(wdata);
            aset_n = 1'b1;
          end else refuse = 1'b1;
        end
        OP_SET_CFG: begin
          if (st_q == SL_OPEN && !cset_q && wdata[1:0] != 2'd3) begin
            cfg_n  = wdata[CFG_W-1:0];
            cset_n = 1'b1;
          end else refuse = 1'b1;
        end
        OP_LOCK: begin
          if (st_q == SL_OPEN && aset_q && cset_q) st_n = SL_LOCKED;
          else refuse = 1'b1;
        end
        OP_EXPORT: refuse = (st_q != SL_LOCKED);
        OP_INVAL: begin
          if (exporting) refuse = 1'b1;
          else begin
            key_n  = '0;
            wr_n   = '0;
            addr_n = '0;
            cfg_n  = '0;
            aset_n = 1'b0;
            cset_n = 1'b0;
            st_n   = INVAL_ST;
          end
        end
        default: refuse = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RESET_ST;
      key_q  <= '0;
      wr_q   <= '0;
      addr_q <= '0;
      cfg_q  <= '0;
      aset_q <= 1'b0;
      cset_q <= 1'b0;
    end else if (upd_en) begin
      st_q   <= st_n;
      key_q  <= key_n;
      wr_q   <= wr_n;
      addr_q <= addr_n;
      cfg_q  <= cfg_n;
      aset_q <= aset_n;
      cset_q <= cset_n;
    end
  end

  assign refuse_o = refuse;
  assign key_o    = key_q;
  assign addr_o   = addr_q;
  assign cfg_o    = cfg_q;

  // R4: key material of a locked slot only changes through invalidation
  a_r4_locked_key_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SL_LOCKED && !(op_en && op == OP_INVAL)) |=> (key_q == $past(key_q)));

  // R2: a repeated write to a filled word leaves the key untouched
  a_r2_word_write_once: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SL_OPEN && op_en && op == OP_WRITE_KEY && wr_q[idx]) |=> (key_q == $past(key_q)));

  // R3: an open slot with a missing field stays open after a lock attempt
  a_r3_lock_needs_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SL_OPEN && op_en && op == OP_LOCK && !(aset_q && cset_q)) |=> (st_q == SL_OPEN));

  // R9: an invalidated hardware slot never comes back before reset
  a_r9_dead_is_final: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SL_DEAD) |=> (st_q == SL_DEAD));
endmodule

// File: rtl/kmu_export_seq.sv
module kmu_export_seq
  import kmu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CFG_W-1:0]  cfg,
  input  logic [WORD_W-1:0] key_word,
  input  logic [WORD_W-1:0] rnd_word,
  input  logic              bus_ready,
  output logic              bus_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_data,
  output logic [IDX_W-1:0]  word_idx,
  output logic              busy,
  output logic              done
);
  logic              busy_q, busy_n;
  logic [IDX_W-1:0]  idx_q, idx_n, last_q, last_n;
  logic              phase_q, phase_n;
  logic [WORD_W-1:0] mask_q, mask_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic              incr_q, incr_n, masked_q, masked_n;
  logic              done_q, done_n;
  logic              fire, word_end, seq_en;

  assign fire     = busy_q & bus_ready;
  assign word_end = fire & (!masked_q | phase_q);
  assign seq_en   = start | fire | done_q;

  always_comb begin
    busy_n   = busy_q;
    idx_n    = idx_q;
    last_n   = last_q;
    phase_n  = phase_q;
    mask_n   = mask_q;
    base_n   = base_q;
    incr_n   = incr_q;
    masked_n = masked_q;
    done_n   = 1'b0;
    if (!busy_q && start) begin
      busy_n   = 1'b1;
      idx_n    = '0;
      phase_n  = 1'b0;
      mask_n   = rnd_word;
      base_n   = base_addr;
      incr_n   = cfg[CFG_INCR];
      masked_n = cfg[CFG_MASK];
      last_n   = IDX_W'(words_for(cfg[1:0]) - 4'd1);
    end else if (fire) begin
      if (!word_end) begin
        phase_n = 1'b1;
      end else if (idx_q == last_q) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end else begin
        idx_n   = idx_q + 1'b1;
        phase_n = 1'b0;
        mask_n  = rnd_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      idx_q    <= '0;
      last_q   <= '0;
      phase_q  <= 1'b0;
      mask_q   <= '0;
      base_q   <= '0;
      incr_q   <= 1'b0;
      masked_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (seq_en) begin
      busy_q   <= busy_n;
      idx_q    <= idx_n;
      last_q   <= last_n;
      phase_q  <= phase_n;
      mask_q   <= mask_n;
      base_q   <= base_n;
      incr_q   <= incr_n;
      masked_q <= masked_n;
      done_q   <= done_n;
    end
  end

  assign bus_valid = busy_q;
  assign bus_addr  = incr_q ? (base_q + (ADDR_W'(idx_q) << 2)) : base_q;
  assign bus_data  = !masked_q ? key_word : (phase_q ? mask_q : (key_word ^ mask_q));
  assign word_idx  = idx_q;
  assign busy      = busy_q;
  assign done      = done_q;

  // R6: a stalled beat keeps its address and data
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_data)));

  // R5: the word index never passes the last word of the chosen size
  a_r5_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q <= last_q));

  // R10: completion follows an accepted beat and lasts one cycle
  a_r10_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(bus_valid && bus_ready) && !busy_q));

  // R7: a mask beat only appears in masked mode
  a_r7_mask_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && phase_q) |-> masked_q);
endmodule

// File: rtl/kmu_keyslot_unit.sv
module kmu_keyslot_unit
  import kmu_pkg::*;
#(
  parameter int                NUM_SLOTS    = 4,
  parameter int                NUM_HW       = 1,
  parameter int                ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] HW_ADDR_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] HW_ADDR_STEP = 32'h0000_0100,
  parameter logic [3:0]        HW_CFG       = 4'b0110,
  localparam int               SLOT_W       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [2:0]                 cmd_op,
  input  logic [SLOT_W-1:0]          cmd_slot,
  input  logic [2:0]                 cmd_idx,
  input  logic [31:0]                cmd_data,
  input  logic                       err_clr,
  output logic [31:0]                rd_data,
  output logic                       err_flag,
  input  logic                       hw_load,
  input  logic [NUM_HW*KEY_BITS-1:0] hw_key,
  input  logic [31:0]                rnd_word,
  output logic                       exp_valid,
  input  logic                       exp_ready,
  output logic [ADDR_W-1:0]          exp_addr,
  output logic [31:0]                exp_data,
  output logic                       exp_busy,
  output logic                       exp_done
);
  kmu_op_e                          op;
  logic [KEY_WORDS-1:0][WORD_W-1:0] key_all  [NUM_SLOTS];
  logic [ADDR_W-1:0]                addr_all [NUM_SLOTS];
  logic [CFG_W-1:0]                 cfg_all  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]             slot_hit, refuse_v;
  logic                             slot_ok, refuse_any, cmd_refused, start;
  logic                             eng_busy;
  logic [IDX_W-1:0]                 eng_idx;
  logic [SLOT_W-1:0]                sel_q;
  logic [WORD_W-1:0]                rd_word, eng_word;
  logic [ADDR_W-1:0]                sel_addr;
  logic [CFG_W-1:0]                 sel_cfg;
  logic [31:0]                      rd_q, rd_n;
  logic                             rd_en;
  logic                             err_q, err_n;

  assign op      = kmu_op_e'(cmd_op);
  assign slot_ok = ({1'b0, cmd_slot} < (SLOT_W+1)'(NUM_SLOTS));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam bit IS_HW = (s < NUM_HW);
    logic [KEY_BITS-1:0] hw_key_s;
    logic                hw_load_s;
    logic                exporting_s;
    if (IS_HW) begin : g_hw
      assign hw_key_s  = hw_key[s*KEY_BITS +: KEY_BITS];
      assign hw_load_s = hw_load;
    end else begin : g_sw
      assign hw_key_s  = '0;
      assign hw_load_s = 1'b0;
    end
    assign slot_hit[s]  = cmd_valid && slot_ok && (cmd_slot == SLOT_W'(s));
    assign exporting_s  = eng_busy && (sel_q == SLOT_W'(s));

    kmu_key_slot #(
      .IS_HW   (IS_HW),
      .ADDR_W  (ADDR_W),
      .DEF_ADDR(HW_ADDR_BASE + ADDR_W'(s) * HW_ADDR_STEP),
      .DEF_CFG (HW_CFG)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_load  (hw_load_s),
      .hw_key   (hw_key_s),
      .op_en    (slot_hit[s]),
      .op       (op),
      .idx      (cmd_idx),
      .wdata    (cmd_data),
      .exporting(exporting_s),
      .refuse_o (refuse_v[s]),
      .key_o    (key_all[s]),
      .addr_o   (addr_all[s]),
      .cfg_o    (cfg_all[s])
    );
  end

  always_comb begin
    rd_word  = '0;
    eng_word = '0;
    sel_addr = '0;
    sel_cfg  = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slot_hit[s]) begin
        rd_word  = key_all[s][cmd_idx];
        sel_addr = addr_all[s];
        sel_cfg  = cfg_all[s];
      end
      if (sel_q == SLOT_W'(s)) eng_word = key_all[s][eng_idx];
    end
  end

  assign refuse_any  = |(slot_hit & refuse_v);
  assign cmd_refused = cmd_valid && (!slot_ok || refuse_any || (op == OP_EXPORT && eng_busy));
  assign start       = cmd_valid && slot_ok && op == OP_EXPORT && !refuse_any && !eng_busy;
  assign rd_en       = cmd_valid && op == OP_READ_KEY;
  assign rd_n        = cmd_refused ? 32'h0 : rd_word;
  assign err_n       = (err_q && !err_clr) || cmd_refused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (start) sel_q <= cmd_slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (rd_en) rd_q <= rd_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else err_q <= err_n;
  end

  kmu_export_seq #(.ADDR_W(ADDR_W)) u_export (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .base_addr(sel_addr),
    .cfg      (sel_cfg),
    .key_word (eng_word),
    .rnd_word (rnd_word),
    .bus_ready(exp_ready),
    .bus_valid(exp_valid),
    .bus_addr (exp_addr),
    .bus_data (exp_data),
    .word_idx (eng_idx),
    .busy     (eng_busy),
    .done     (exp_done)
  );

  assign rd_data  = rd_q;
  assign err_flag = err_q;
  assign exp_busy = eng_busy;

  // R10: a refused command always leaves the error flag raised
  a_r10_refusal_flags: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_refused |=> err_flag);

  // R5: a second export cannot start while one is running
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_busy && cmd_valid && op == OP_EXPORT) |=> (err_flag && $stable(sel_q)));
endmodule

// File: tb/kmu_keyslot_unit_bench.sv
module kmu_keyslot_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] WR = 3'd0, RD = 3'd1, SA = 3'd2, SC = 3'd3,
                         LK = 3'd4, EX = 3'd5, IV = 3'd6, RS = 3'd7;
  localparam int NV = 22;
  // fields: req[77:74] op[73:71] slot[70:69] idx[68:66] data[65:34] err[33] chk[32] rd[31:0]
  localparam logic [77:0] VECS [NV] = '{
    {4'd2,  WR, 2'd1, 3'd0, 32'hA1A1A1A1, 1'b0, 1'b0, 32'h0},        // R2
    {4'd2,  WR, 2'd1, 3'd1, 32'hB2B2B2B2, 1'b0, 1'b0, 32'h0},        // R2
    {4'd2,  WR, 2'd1, 3'd0, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h0},        // R2 second write
    {4'd2,  RD, 2'd1, 3'd0, 32'h0,        1'b0, 1'b1, 32'hA1A1A1A1}, // R2 unchanged
    {4'd2,  RD, 2'd1, 3'd2, 32'h0,        1'b0, 1'b1, 32'h0},        // R2 unwritten
    {4'd3,  LK, 2'd1, 3'd0, 32'h0,        1'b1, 1'b0, 32'h0},        // R3 nothing set
    {4'd3,  SA, 2'd1, 3'd0, 32'h00001000, 1'b0, 1'b0, 32'h0},        // R3
    {4'd3,  LK, 2'd1, 3'd0, 32'h0,        1'b1, 1'b0, 32'h0},        // R3 cfg missing
    {4'd3,  SC, 2'd1, 3'd0, 32'h3,        1'b1, 1'b0, 32'h0},        // R3 bad size
    {4'd3,  SC, 2'd1, 3'd0, 32'h4,        1'b0, 1'b0, 32'h0},        // R3
    {4'd3,  SC, 2'd1, 3'd0, 32'h5,        1'b1, 1'b0, 32'h0},        // R3 cfg once
    {4'd3,  SA, 2'd1, 3'd0, 32'h00002222, 1'b1, 1'b0, 32'h0},        // R3 addr once
    {4'd5,  EX, 2'd1, 3'd0, 32'h0,        1'b1, 1'b0, 32'h0},        // R5 not locked
    {4'd2,  RD, 2'd1, 3'd1, 32'h0,        1'b0, 1'b1, 32'hB2B2B2B2}, // R2
    {4'd3,  LK, 2'd1, 3'd0, 32'h0,        1'b0, 1'b0, 32'h0},        // R3 lock ok
    {4'd4,  RD, 2'd1, 3'd1, 32'h0,        1'b1, 1'b1, 32'h0},        // R4 read hidden
    {4'd4,  WR, 2'd1, 3'd2, 32'h12345678, 1'b1, 1'b0, 32'h0},        // R4
    {4'd4,  SC, 2'd1, 3'd0, 32'h6,        1'b1, 1'b0, 32'h0},        // R4
    {4'd4,  LK, 2'd1, 3'd0, 32'h0,        1'b1, 1'b0, 32'h0},        // R4 relock
    {4'd8,  EX, 2'd0, 3'd0, 32'h0,        1'b1, 1'b0, 32'h0},        // R8 before load
    {4'd8,  RD, 2'd0, 3'd0, 32'h0,        1'b1, 1'b1, 32'h0},        // R8
    {4'd10, RS, 2'd2, 3'd0, 32'h0,        1'b1, 1'b0, 32'h0}         // R10 reserved op
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid, err_clr, hw_load, exp_ready;
  logic [2:0]   cmd_op, cmd_idx;
  logic [1:0]   cmd_slot;
  logic [31:0]  cmd_data, rd_data, rnd_word, exp_data;
  logic [31:0]  exp_addr;
  logic [255:0] hw_key;
  logic         err_flag, exp_valid, exp_busy, exp_done;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [31:0] got_a [16];
  logic [31:0] got_d [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    rnd_word <= (cyc + 1) * 32'h9E3779B9 + 32'h01234567;
  end

  kmu_keyslot_unit u_kmu_keyslot_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_slot(cmd_slot), .cmd_idx(cmd_idx), .cmd_data(cmd_data), .err_clr(err_clr),
    .rd_data(rd_data), .err_flag(err_flag), .hw_load(hw_load), .hw_key(hw_key),
    .rnd_word(rnd_word), .exp_valid(exp_valid), .exp_ready(exp_ready),
    .exp_addr(exp_addr), .exp_data(exp_data), .exp_busy(exp_busy), .exp_done(exp_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input int slot, input logic [2:0] idx,
                        input logic [31:0] d, input logic clr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_slot = 2'(slot); cmd_idx = idx; cmd_data = d;
    err_clr = clr;
    @(negedge clk);
    cmd_valid = 1'b0; err_clr = 1'b0;
  endtask

  task automatic collect(input bit bp, output int n, output bit done_seen);
    int  k = 0;
    bit  pv = 0, pr = 0;
    logic [31:0] pa = '0, pd = '0;
    n = 0; done_seen = 0;
    while (!done_seen && k < 400) begin
      @(negedge clk);
      k++;
      if (exp_done) done_seen = 1;
      else begin
        if (pv && !pr && exp_valid) begin
          chk("R6 stall hold addr", exp_addr, pa);
          chk("R6 stall hold data", exp_data, pd);
        end
        exp_ready = bp ? (k % 3 != 1) : 1'b1;
        pv = exp_valid; pr = exp_ready; pa = exp_addr; pd = exp_data;
        if (exp_valid && exp_ready && n < 16) begin
          got_a[n] = exp_addr; got_d[n] = exp_data; n++;
        end
      end
    end
    exp_ready = 1'b0;
    chk("R10 done pulse seen", 32'(done_seen), 32'd1);
    @(negedge clk);
    chk("R10 done lasts one cycle", 32'(exp_done), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    bit ds;
    logic [31:0] k2 [6];
    logic [31:0] ha, hd;
    rst_n = 1'b0; cmd_valid = 1'b0; err_clr = 1'b0; hw_load = 1'b0; exp_ready = 1'b0;
    cmd_op = '0; cmd_idx = '0; cmd_slot = '0; cmd_data = '0; rnd_word = 32'h5A5A0001;
    for (int i = 0; i < 8; i++) hw_key[i*32 +: 32] = 32'hC0DE0000 + 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 exp_valid", 32'(exp_valid), 0);
    chk("R1 exp_busy", 32'(exp_busy), 0);
    chk("R1 exp_done", 32'(exp_done), 0);
    chk("R1 err_flag", 32'(err_flag), 0);
    chk("R1 rd_data", rd_data, 0);
    do_cmd(RD, 3, 3'd0, 0, 1'b1);
    chk("R1 open slot readable", 32'(err_flag), 0);
    chk("R1 empty slot", rd_data, 0);

    // table of access-rule vectors
    for (int v = 0; v < NV; v++) begin
      logic [77:0] e;
      e = VECS[v];
      do_cmd(e[73:71], int'(e[70:69]), e[68:66], e[65:34], 1'b1);
      chk($sformatf("R%0d vec%0d err", e[77:74], v), 32'(err_flag), 32'(e[33]));
      if (e[32]) chk($sformatf("R%0d vec%0d rd", e[77:74], v), rd_data, e[31:0]);
    end

    // R5 R6: 128-bit unmasked rising export from slot 1 with backpressure
    do_cmd(EX, 1, 3'd0, 0, 1'b1);
    chk("R5 export accepted", 32'(err_flag), 0);
    collect(1'b1, n, ds);
    chk("R5 beats for 128 bits", 32'(n), 4);
    for (int i = 0; i < 4; i++) begin
      chk("R6 rising address", got_a[i], 32'h1000 + 32'(4*i));
      chk("R5 word order", got_d[i], (i == 0) ? 32'hA1A1A1A1 : (i == 1) ? 32'hB2B2B2B2 : 32'h0);
    end

    // R7: 192-bit masked export from slot 2 to a fixed address
    for (int i = 0; i < 6; i++) begin
      k2[i] = 32'h31415900 + 32'(i * 17);
      do_cmd(WR, 2, 3'(i), k2[i], 1'b1);
    end
    do_cmd(SA, 2, 3'd0, 32'h2000, 1'b1);
    do_cmd(SC, 2, 3'd0, 32'h9, 1'b1);
    do_cmd(LK, 2, 3'd0, 0, 1'b1);
    chk("R3 slot2 lock", 32'(err_flag), 0);
    do_cmd(EX, 2, 3'd0, 0, 1'b1);
    chk("R5 slot2 export", 32'(exp_valid), 1);
    ha = exp_addr; hd = exp_data;
    do_cmd(EX, 1, 3'd0, 0, 1'b1);
    chk("R5 export while busy refused", 32'(err_flag), 1);
    do_cmd(IV, 2, 3'd0, 0, 1'b1);
    chk("R9 invalidate during export refused", 32'(err_flag), 1);
    chk("R6 held addr", exp_addr, ha);
    chk("R6 held data", exp_data, hd);
    collect(1'b1, n, ds);
    chk("R7 beats for masked 192 bits", 32'(n), 12);
    for (int i = 0; i < 6; i++) begin
      chk("R6 fixed address", got_a[2*i], 32'h2000);
      chk("R7 mask beat same address", got_a[2*i+1], 32'h2000);
      chk("R7 pair unmasks", got_d[2*i] ^ got_d[2*i+1], k2[i]);
      if (i > 0) chk("R7 fresh mask", 32'(got_d[2*i+1] != got_d[2*i-1]), 1);
    end
    chk("R7 masked beat hides word", 32'(got_d[0] != k2[0]), 1);

    // R8: hardware slot load and export with defaults
    @(negedge clk); hw_load = 1'b1;
    @(negedge clk); hw_load = 1'b0;
    do_cmd(RD, 0, 3'd0, 0, 1'b1);
    chk("R8 loaded slot locked", 32'(err_flag), 1);
    chk("R8 loaded slot hidden", rd_data, 0);
    for (int i = 0; i < 8; i++) hw_key[i*32 +: 32] = 32'hBAD00000 + 32'(i);
    @(negedge clk); hw_load = 1'b1;
    @(negedge clk); hw_load = 1'b0;
    do_cmd(EX, 0, 3'd0, 0, 1'b1);
    chk("R8 hw export accepted", 32'(err_flag), 0);
    collect(1'b0, n, ds);
    chk("R8 beats for 256 bits", 32'(n), 8);
    for (int i = 0; i < 8; i++) begin
      chk("R8 default address", got_a[i], 32'h40000000 + 32'(4*i));
      chk("R8 first load kept", got_d[i], 32'hC0DE0000 + 32'(i));
    end

    // R9: invalidation of software and hardware slots
    do_cmd(IV, 1, 3'd0, 0, 1'b1);
    chk("R9 sw invalidate", 32'(err_flag), 0);
    do_cmd(RD, 1, 3'd0, 0, 1'b1);
    chk("R9 sw slot open again", 32'(err_flag), 0);
    chk("R9 key erased", rd_data, 0);
    do_cmd(WR, 1, 3'd0, 32'h77, 1'b1);
    do_cmd(RD, 1, 3'd0, 0, 1'b1);
    chk("R9 sw slot reusable", rd_data, 32'h77);
    do_cmd(IV, 0, 3'd0, 0, 1'b1);
    chk("R9 hw invalidate", 32'(err_flag), 0);
    @(negedge clk); hw_load = 1'b1;
    @(negedge clk); hw_load = 1'b0;
    do_cmd(EX, 0, 3'd0, 0, 1'b1);
    chk("R9 hw slot dead", 32'(err_flag), 1);
    chk("R9 no export from dead slot", 32'(exp_valid), 0);
    do_cmd(SA, 0, 3'd0, 32'h10, 1'b1);
    chk("R9 dead slot not reusable", 32'(err_flag), 1);

    // R10: stickiness and clearing
    do_cmd(LK, 3, 3'd0, 0, 1'b1);
    chk("R10 refused lock", 32'(err_flag), 1);
    do_cmd(RD, 3, 3'd0, 0, 1'b0);
    chk("R10 error sticks", 32'(err_flag), 1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk("R10 error cleared", 32'(err_flag), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule